// File: doc/BRIEF.md
# Pipelined Four-Operand Carry-Save Summer

This block adds four unsigned operands that arrive together on every clock cycle. Two carry-save stages built from full-adder cells reduce the four operands to one pair of buses. The first stage folds three operands into a parity bus and a majority bus. The second stage folds that pair and the fourth operand into a new pair. A ripple adder then resolves the last pair into a single binary sum.

A register rank follows each stage, so the slowest single stage sets the clock period. The first result appears a fixed three cycles after its operands. After that, a fresh sum leaves the block on every cycle. A valid flag travels alongside the data through a matching shift register, and the synchronous reset empties that shift register.

Top module: `mcsa_pipe`

## Requirements
- R1: When `sum_out_vld` is high, `sum_out` equals the arithmetic sum of the four operands that were presented with `in_vld` high exactly three rising clock edges earlier.
- R2: `sum_out_vld` is `in_vld` delayed by exactly three rising clock edges that had reset released.
- R3: `sum_out` is OPW+2 bits wide (6 bits by default). When all four operands are at their maximum of 15, the result is 60, with no wraparound.
- R4: On a rising edge where `rst_n` is low, the valid pipeline is cleared, so `sum_out_vld` is low on the following cycle. After reset is released, no stale valid appears.
- R5: The block accepts a new operand set on every cycle. Back-to-back valid inputs produce back-to-back results in the same order.
- R6: Each carry-save stage forms, per bit, the 3-input parity and the 2-of-3 majority, with no carry passing between bit positions. The carry bus moves one position up before the next stage, so each stage keeps the numeric total of its inputs.
- R7: The final ripple adder takes a carry-in of 0 at its lowest bit, so all-zero operands give a sum of 0.
- R8: Operands presented with `in_vld` low never raise `sum_out_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the valid pipeline |
| in_vld | input | 1 | Marks the operand set on this cycle as valid |
| opd_a | input | OPW (4) | First unsigned operand |
| opd_b | input | OPW (4) | Second unsigned operand |
| opd_c | input | OPW (4) | Third unsigned operand |
| opd_d | input | OPW (4) | Fourth unsigned operand |
| sum_out_vld | output | 1 | Marks `sum_out` as holding a result |
| sum_out | output | OPW+2 (6) | Sum of the four operands |

## Verification
The end-to-end assertions assume only that the operands are ordinary 2-state values and that the history they compare against is no older than the edges since reset was released. A counter in the top module blocks each check until enough edges without reset have passed. The data registers are never reset, so the sum checks look only at cycles where the valid flag is high. The stimulus drives every input at the falling edge. It mixes random operand values over the full 0 to 15 range with a random valid pattern, and it adds directed all-ones, all-zero, bubble and mid-stream reset cases.

// File: rtl/mcsa_pkg.sv
// Shared constants for the four-operand carry-save summer.
// Assumes the tree shape is fixed at four operands and two carry-save levels.
package mcsa_pkg;
    localparam int unsigned NUM_OPS = 4;
    localparam int unsigned LATENCY = 3;

    // Width needed to hold the sum of NUM_OPS operands of opw bits.
    function automatic int unsigned sum_width(input int unsigned opw);
        return opw + $clog2(NUM_OPS);
    endfunction
endpackage

// File: rtl/csa_stage.sv
// One carry-save level: a row of W independent full-adder cells.
// Each bit gives parity and majority of its three inputs; nothing crosses bits.
// Assumes the caller applies the one-bit weight shift to the majority bus.
module csa_stage #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic [W-1:0] z_in,
    output logic [W-1:0] par_out,
    output logic [W-1:0] maj_out
);
    for (genvar i = 0; i < W; i++) begin : g_fa
        // Per-bit full adder: parity and 2-of-3 majority.
        always_comb begin
            par_out[i] = x_in[i] ^ y_in[i] ^ z_in[i];
            maj_out[i] = (x_in[i] & y_in[i]) | (x_in[i] & z_in[i]) | (y_in[i] & z_in[i]);
        end
    end
endmodule

// File: rtl/cpa_ripple.sv
// Carry-propagate adder of width W with carry-in tied to zero.
// Assumes the true sum fits in W bits, so the final carry-out is not produced.
module cpa_ripple #(
    parameter int unsigned W = 6
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] s_out
);
    logic [W-1:0] cy;

    // Lowest position sees no carry (R7).
    assign cy[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Sum bit from operands and incoming ripple carry.
        assign s_out[i] = a_in[i] ^ b_in[i] ^ cy[i];
        if (i < W - 1) begin : g_cy
            // Carry into the next position.
            assign cy[i+1] = (a_in[i] & b_in[i]) | (a_in[i] & cy[i]) | (b_in[i] & cy[i]);
        end
    end
endmodule

// File: rtl/mcsa_pipe.sv
// Top of the pipelined four-operand summer.
// Rank 1: first carry-save level on operands a, b and c, with d carried along.
// Rank 2: second carry-save level folding in d.
// Rank 3: ripple adder result.
// Assumes unsigned operands and no stall; reset clears only the valid chain.
module mcsa_pipe
    import mcsa_pkg::*;
#(
    parameter int unsigned OPW = 4,
    localparam int unsigned SW = sum_width(OPW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_vld,
    input  logic [OPW-1:0] opd_a,
    input  logic [OPW-1:0] opd_b,
    input  logic [OPW-1:0] opd_c,
    input  logic [OPW-1:0] opd_d,
    output logic           sum_out_vld,
    output logic [SW-1:0]  sum_out
);
    localparam int unsigned W2 = OPW + 1;
    localparam logic [SW-1:0] MAX_SUM = SW'(NUM_OPS * ((1 << OPW) - 1));

    logic [OPW-1:0] l1_par, l1_maj;
    logic [OPW-1:0] r1_par, r1_d;
    logic [OPW:0]   r1_car;
    logic [W2-1:0]  l2_par, l2_maj;
    logic [W2-1:0]  r2_par;
    logic [W2:0]    r2_car;
    logic [SW-1:0]  cpa_sum;
    logic [LATENCY-1:0] vld_q;

    csa_stage #(.W(OPW)) u_lvl1 (
        .x_in(opd_a), .y_in(opd_b), .z_in(opd_c),
        .par_out(l1_par), .maj_out(l1_maj)
    );

    // Rank 1: keep the first pair, with carries moved up one weight, plus operand d.
    always_ff @(posedge clk) begin
        r1_par <= l1_par;
        r1_car <= {l1_maj, 1'b0};
        r1_d   <= opd_d;
    end

    csa_stage #(.W(W2)) u_lvl2 (
        .x_in({1'b0, r1_par}), .y_in(r1_car), .z_in({1'b0, r1_d}),
        .par_out(l2_par), .maj_out(l2_maj)
    );

    // Rank 2: keep the second pair, with carries moved up one weight.
    always_ff @(posedge clk) begin
        r2_par <= l2_par;
        r2_car <= {l2_maj, 1'b0};
    end

    cpa_ripple #(.W(SW)) u_cpa (
        .a_in(SW'(r2_par)), .b_in(r2_car), .s_out(cpa_sum)
    );

    // Rank 3: register the resolved sum.
    always_ff @(posedge clk) begin
        sum_out <= cpa_sum;
    end

    // Valid chain, one bit per rank, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[LATENCY-2:0], in_vld};
    end

    assign sum_out_vld = vld_q[LATENCY-1];

    // ---------------- assertions ----------------
    logic [1:0]    run_cnt;
    logic [SW-1:0] in_total;

    // Count edges since reset release, saturating at the latency.
    always_ff @(posedge clk) begin
        if (!rst_n)                  run_cnt <= '0;
        else if (run_cnt != 2'd3)    run_cnt <= run_cnt + 2'd1;
    end

    assign in_total = SW'(opd_a) + SW'(opd_b) + SW'(opd_c) + SW'(opd_d);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == 2'd3) |-> (sum_out_vld == $past(in_vld, 3)));

    assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == 2'd3 && sum_out_vld) |-> (sum_out == $past(in_total, 3)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sum_out_vld |-> (sum_out <= MAX_SUM));

    assert_reset_clear_R4: assert property (@(posedge clk)
        !rst_n |=> !sum_out_vld);

    assert_conserve_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 2'd2) |->
        ((SW'(r2_par) + SW'(r2_car)) ==
         $past(SW'(r1_par) + SW'(r1_car) + SW'(r1_d))));

    assert_bubble_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == 2'd3 && !$past(in_vld, 3)) |-> !sum_out_vld);
endmodule

// File: tb/test_mcsa_pipe.sv
`timescale 1ns/1ps
module test_mcsa_pipe;
    localparam int unsigned OPW = 4;
    localparam int unsigned SW  = OPW + 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_vld = 1'b0;
    logic [OPW-1:0] opd_a = '0, opd_b = '0, opd_c = '0, opd_d = '0;
    logic           sum_out_vld;
    logic [SW-1:0]  sum_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench pipeline model: valid and expected sum per rank.
    logic          mv [3];
    logic [SW-1:0] ms [3];

    mcsa_pipe #(.OPW(OPW)) i_mcsa_pipe (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .opd_a(opd_a), .opd_b(opd_b), .opd_c(opd_c), .opd_d(opd_d),
        .sum_out_vld(sum_out_vld), .sum_out(sum_out)
    );

    always #4 clk = ~clk;

    function automatic logic [SW-1:0] ref_sum(input logic [OPW-1:0] a, b, c, d);
        int t;
        t = int'(a) + int'(b) + int'(c) + int'(d);
        return SW'(t);
    endfunction

    task automatic chk(input string req, input bit ok, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    // Apply one cycle of inputs, advance the model, compare at the next falling edge.
    task automatic step(input string req, input logic v,
                        input logic [OPW-1:0] a, b, c, d);
        in_vld = v; opd_a = a; opd_b = b; opd_c = c; opd_d = d;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin mv[i] = 1'b0; ms[i] = '0; end
        end else begin
            mv[2] = mv[1]; ms[2] = ms[1];
            mv[1] = mv[0]; ms[1] = ms[0];
            mv[0] = v;     ms[0] = ref_sum(a, b, c, d);
        end
        @(negedge clk);
        chk({req, " valid"}, sum_out_vld === mv[2], int'(sum_out_vld), int'(mv[2]));
        if (mv[2])
            chk({req, " sum"}, sum_out === ms[2], int'(sum_out), int'(ms[2]));
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        for (int i = 0; i < 3; i++) begin mv[i] = 1'b0; ms[i] = '0; end
        seed = $urandom(32'h5A17);
        @(negedge clk);

        // R4: reset held with valid inputs present keeps output valid low.
        rst_n = 1'b0;
        for (int k = 0; k < 4; k++) step("R4 reset", 1'b1, 4'hF, 4'hF, 4'hF, 4'hF);
        rst_n = 1'b1;

        // R7: all zero operands give zero.
        step("R7 zero", 1'b1, 4'h0, 4'h0, 4'h0, 4'h0);
        // R3: maximum operands give 60.
        step("R3 max", 1'b1, 4'hF, 4'hF, 4'hF, 4'hF);
        // R6: heavy carries in the first level, d empty.
        step("R6 carries", 1'b1, 4'hF, 4'hF, 4'hF, 4'h0);
        step("R6 mixed", 1'b1, 4'hA, 4'h5, 4'hA, 4'h5);
        // R5: back-to-back distinct results.
        for (int k = 0; k < 6; k++)
            step("R5 stream", 1'b1, 4'(k), 4'(k + 1), 4'(15 - k), 4'(2 * k));
        // R8: bubbles with large data stay invisible.
        for (int k = 0; k < 4; k++) step("R8 bubble", 1'b0, 4'hF, 4'hF, 4'hF, 4'hF);
        // R2: alternating valid pattern.
        for (int k = 0; k < 6; k++) step("R2 alternate", 1'(k % 2), 4'(k), 4'h3, 4'h7, 4'h1);

        // R4: reset in the middle of a full pipeline, then flush with bubbles.
        for (int k = 0; k < 3; k++) step("R4 fill", 1'b1, 4'h9, 4'h8, 4'h7, 4'h6);
        rst_n = 1'b0;
        step("R4 midreset", 1'b1, 4'h1, 4'h1, 4'h1, 4'h1);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) step("R4 after", 1'b0, 4'h2, 4'h2, 4'h2, 4'h2);

        // R1: random operands and random valid pattern.
        for (int k = 0; k < 400; k++)
            step("R1 random", 1'($urandom % 4 != 0), 4'($urandom), 4'($urandom),
                 4'($urandom), 4'($urandom));
        // Drain.
        for (int k = 0; k < 3; k++) step("R1 drain", 1'b0, 4'h0, 4'h0, 4'h0, 4'h0);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule